// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel flash device. A program or erase command has already been sent to the device by other logic. The block then reads one target address over and over, and decides from the device's status bits when the operation has finished. It takes a single start handshake that carries the operation kind (program or erase), the polling method, the target address and, for a program, the word just written. It issues reads over a valid/ready request channel and accepts the 16-bit words that come back on a valid/ready response channel. When it stops, it raises a one-cycle `done` pulse together with exactly one result flag: `ok`, `mismatch` or `timeout`.

Two detection methods are offered. The first is data-bit-7 polling. During a program, bit 7 reads as the inverse of the written bit 7. During an erase, bit 7 reads as 0. Completion must be seen on two reads in a row before it is accepted. The second is the bit-6 toggle method. Bit 6 flips on every read while the device is busy, so two consecutive reads with equal bit 6 mean the operation is finished. Once a program is finished, the whole returned word is compared with the written data. A parameter caps the number of reads so that a stuck device cannot hang the host.

Back-pressure rules. A start is taken only in a cycle where `start_valid` and `start_ready` are both high, and `start_ready` is high only while the block is idle. `rd_req_valid`, once raised, stays high with an unchanged `rd_req_addr` until `rd_req_ready` is seen. Only one read is ever outstanding, and `rd_rsp_ready` is high only while that read is awaited.

Top module: `flash_poll_engine`

## Requirements
- R1: A start is accepted only when `start_valid` and `start_ready` are both high. `start_ready` is high exactly while `busy` is low, and `busy` is high in the cycle after an accepted start.
- R2: While `busy` is high, `start_valid` and the start fields have no effect: the polled address and the final result stay those of the running operation.
- R3: `rd_req_valid` holds with a stable `rd_req_addr` until `rd_req_ready`. Every read uses the latched target address, and no new request is made before the previous response has been taken.
- R4: Bit-7 method (`start_toggle`=0). The expected bit 7 is `start_data[7]` for a program (`start_erase`=0) and 1 for an erase (`start_erase`=1). The operation is complete at the second of two consecutive responses whose bit 7 both equal the expected value.
- R5: In the bit-7 method, a single matching response followed by a non-matching one does not complete the operation, and polling continues.
- R6: Toggle method (`start_toggle`=1). The operation is complete at the first response whose bit 6 equals bit 6 of the preceding response of the same operation. The first response never completes it.
- R7: At program completion, `ok`=1 if the full 16-bit response equals `start_data`; otherwise `mismatch`=1 and `ok`=0.
- R8: At erase completion, `ok`=1 and `mismatch` stays 0 whatever the returned word.
- R9: If `MAX_POLLS` responses arrive without completion, polling stops with `timeout`=1 and `ok`=0, after exactly `MAX_POLLS` reads.
- R10: `done` is a one-cycle pulse in the cycle after the final response handshake. At most one of `ok`, `timeout`, `mismatch` is high. They hold until the next accepted start clears them. After reset the block is idle with all outputs low except `start_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Block idle, start can be taken |
| start_erase | input | 1 | 1 = erase operation, 0 = program |
| start_toggle | input | 1 | 1 = bit-6 toggle method, 0 = bit-7 method |
| start_addr | input | ADDR_W | Address to poll |
| start_data | input | 16 | Word written by the program operation |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by the bus |
| rd_req_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block waiting for read data |
| rd_rsp_data | input | 16 | Word returned by the device |
| busy | output | 1 | Operation being tracked |
| done | output | 1 | One-cycle end-of-tracking pulse |
| ok | output | 1 | Operation finished correctly |
| timeout | output | 1 | Read budget exhausted |
| mismatch | output | 1 | Program finished with wrong data |

## Verification
The device model returns busy words for a chosen number of reads and then a chosen final word. Programs and erases are each run under both methods, so the two expected bit-7 values and the toggle rule are separated. A zero-length busy phase shows that the first read alone never ends polling. A single early bit-7 match exposes a missing confirmation read. A wrong final word with correct bit 7 separates the full-word compare from the status check, and the same wrong word on an erase shows that erases skip that compare. Never-ending busy phases under each method hit the read budget exactly, and a start pulse during a long operation with a different address must leave both the reads and the result unchanged.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int WORD_W = 16;
  localparam int STS_B7 = 7;
  localparam int STS_B6 = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fpe_state_e;
endpackage

// File: rtl/fpe_status_eval.sv
module fpe_status_eval (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic use_toggle,
  input  logic expect_b7,
  input  logic rsp_b7,
  input  logic rsp_b6,
  output logic complete
);
  logic have_prev_q;
  logic prev_b6_q;
  logic confirm_q;
  logic b7_hit;

  assign b7_hit = (rsp_b7 == expect_b7);

  always_comb begin
    if (use_toggle) complete = have_prev_q && (rsp_b6 == prev_b6_q);
    else            complete = confirm_q && b7_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_prev_q <= 1'b0;
      prev_b6_q   <= 1'b0;
      confirm_q   <= 1'b0;
    end else if (take) begin
      have_prev_q <= 1'b1;
      prev_b6_q   <= rsp_b6;
      confirm_q   <= !use_toggle && b7_hit;
    end
  end

  // R5: a pending confirmation only exists in bit-7 mode
  p_confirm_b7_r5: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_q |-> !use_toggle);
  // R6: toggle completion never on the first response
  p_first_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && use_toggle && !have_prev_q) |-> !complete);
endmodule

// File: rtl/fpe_poll_budget.sv
module fpe_poll_budget #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic at_limit
);
  localparam int CNT_W = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign at_limit = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (step && !at_limit) cnt_q <= cnt_q + 1'b1;
  end

  // R9: count never passes the last allowed read
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import fpe_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int MAX_POLLS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              start_erase,
  input  logic              start_toggle,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] start_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              timeout,
  output logic              mismatch
);
  fpe_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              erase_q;
  logic              toggle_q;
  logic              accept;
  logic              take;
  logic              complete;
  logic              at_limit;
  logic              word_bad;

  assign start_ready  = (state_q == ST_IDLE);
  assign busy         = !start_ready;
  assign accept       = start_valid && start_ready;
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_rsp_ready = (state_q == ST_WAIT);
  assign rd_req_addr  = addr_q;
  assign take         = rd_rsp_valid && rd_rsp_ready;
  assign word_bad     = !erase_q && (rd_rsp_data != data_q);

  fpe_status_eval u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept),
    .take       (take),
    .use_toggle (toggle_q),
    .expect_b7  (erase_q | data_q[STS_B7]),
    .rsp_b7     (rd_rsp_data[STS_B7]),
    .rsp_b6     (rd_rsp_data[STS_B6]),
    .complete   (complete)
  );

  fpe_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .step     (take),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      erase_q  <= 1'b0;
      toggle_q <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      timeout  <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_REQ;
          addr_q   <= start_addr;
          data_q   <= start_data;
          erase_q  <= start_erase;
          toggle_q <= start_toggle;
          ok       <= 1'b0;
          timeout  <= 1'b0;
          mismatch <= 1'b0;
        end
        ST_REQ: if (rd_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (take) begin
          if (complete) begin
            state_q  <= ST_IDLE;
            done     <= 1'b1;
            ok       <= !word_bad;
            mismatch <= word_bad;
          end else if (at_limit) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            timeout <= 1'b1;
          end else begin
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: accepted start makes the block busy next cycle
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R2: target address frozen while tracking
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
  // R3: request held with stable address under back-pressure
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R3: never request and accept data in the same cycle
  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));
  // R8: erase never reports a data mismatch
  p_mis_prog_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> !erase_q);
  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: result flags mutually exclusive
  p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, timeout, mismatch}));
  // R10: flags only change on start or completion
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !take) |=> $stable({ok, timeout, mismatch}));
endmodule

// File: tb/flash_poll_engine_tb_top.sv
module flash_poll_engine_tb_top;
  localparam int ADDR_W = 18;
  localparam int MAXP   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_valid = 1'b0;
  logic              start_ready;
  logic              start_erase = 1'b0;
  logic              start_toggle = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [15:0]       start_data = '0;
  logic              rd_req_valid;
  logic              rd_req_ready;
  logic [ADDR_W-1:0] rd_req_addr;
  logic              rd_rsp_valid;
  logic              rd_rsp_ready;
  logic [15:0]       rd_rsp_data;
  logic              busy, done, ok, timeout, mismatch;

  always #5 clk = ~clk;

  flash_poll_engine #(.ADDR_W(ADDR_W), .MAX_POLLS(MAXP)) dut_i (.*);

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model state
  logic              m_erase, m_toggle;
  logic [15:0]       m_data, m_fin;
  logic [ADDR_W-1:0] m_addr;
  int                m_busy, m_glitch;

  function automatic logic [15:0] dev_word(input int k);
    logic [15:0] w;
    if (k >= m_busy) return m_fin;
    w = m_erase ? 16'h0000 : m_data;
    w[7] = m_erase ? 1'b0 : ~m_data[7];
    w[6] = k[0];
    if (k == m_glitch) w[7] = m_erase ? 1'b1 : m_data[7];
    return w;
  endfunction

  typedef struct { bit ok; bit to; bit mis; int reads; } exp_t;
  exp_t sb_q[$];

  int cyc = 0, lat = 0, k_idx = 0, rd_seen = 0;
  logic pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      pend <= 1'b0;
      k_idx <= 0;
      rd_seen <= 0;
    end else begin
      cyc <= cyc + 1;
      rd_req_ready <= (cyc % 3) != 1;
      if (start_valid && start_ready) begin
        k_idx <= 0;
        rd_seen <= 0;
      end
      if (rd_req_valid && rd_req_ready) begin
        chk(rd_req_addr == m_addr, "R3", "read address", rd_req_addr, m_addr);
        chk(!pend, "R3", "request while outstanding", pend, 0);
        pend <= 1'b1;
        lat <= 2;
        rd_rsp_data <= dev_word(k_idx);
        k_idx <= k_idx + 1;
      end
      if (pend && !rd_rsp_valid) begin
        if (lat <= 1) rd_rsp_valid <= 1'b1;
        else lat <= lat - 1;
      end
      if (rd_rsp_valid && rd_rsp_ready) begin
        rd_rsp_valid <= 1'b0;
        pend <= 1'b0;
        rd_seen <= rd_seen + 1;
      end
    end
  end

  // scoreboard monitor
  bit hold_chk = 0;
  exp_t last_e;
  always @(negedge clk) begin
    if (rst_n && hold_chk) begin
      hold_chk = 0;
      chk(!done, "R10", "done pulse width", done, 0);
      chk(ok == last_e.ok && timeout == last_e.to && mismatch == last_e.mis,
          "R10", "flags held", {ok, timeout, mismatch}, {last_e.ok, last_e.to, last_e.mis});
    end
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk(0, "R10", "unexpected done", 1, 0);
      end else begin
        last_e = sb_q.pop_front();
        chk(ok == last_e.ok, last_e.to ? "R9" : (m_erase ? "R8" : "R7"), "ok", ok, last_e.ok);
        chk(mismatch == last_e.mis, m_erase ? "R8" : "R7", "mismatch", mismatch, last_e.mis);
        chk(timeout == last_e.to, "R9", "timeout", timeout, last_e.to);
        chk(rd_seen == last_e.reads, m_toggle ? "R6" : "R4", "read count", rd_seen, last_e.reads);
        hold_chk = 1;
      end
    end
  end

  function automatic exp_t predict();
    exp_t e;
    bit conf = 0;
    logic p6 = 1'b0;
    logic e7 = m_erase ? 1'b1 : m_data[7];
    logic [15:0] w;
    e.ok = 0; e.to = 1; e.mis = 0; e.reads = MAXP;
    for (int k = 0; k < MAXP; k++) begin
      bit fin = 0;
      w = dev_word(k);
      if (m_toggle) begin
        fin = (k > 0) && (w[6] == p6);
        p6 = w[6];
      end else begin
        fin = conf && (w[7] == e7);
        conf = (w[7] == e7);
      end
      if (fin) begin
        e.to = 0;
        e.reads = k + 1;
        e.mis = !m_erase && (w != m_data);
        e.ok = !e.mis;
        return e;
      end
    end
    return e;
  endfunction

  task automatic run_op(input bit er, input bit tg, input logic [ADDR_W-1:0] a,
                        input logic [15:0] d, input logic [15:0] f,
                        input int nb, input int gl, input bit poke);
    @(negedge clk);
    m_erase = er; m_toggle = tg; m_addr = a; m_data = d; m_fin = f;
    m_busy = nb; m_glitch = gl;
    sb_q.push_back(predict());
    start_erase = er; start_toggle = tg; start_addr = a; start_data = d;
    chk(start_ready && !busy, "R1", "ready while idle", start_ready, 1);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk(busy && !start_ready, "R1", "busy after accept", busy, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      start_addr = a ^ 18'h155; start_data = ~d; start_erase = ~er; start_toggle = ~tg;
      start_valid = 1'b1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!start_ready, "R2", "start_ready low while busy", start_ready, 0);
      end
      start_valid = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(start_ready && !busy, "R10", "reset idle", busy, 0);
    chk(!done && !ok && !timeout && !mismatch, "R10", "reset flags",
        {done, ok, timeout, mismatch}, 0);
    chk(!rd_req_valid && !rd_rsp_ready, "R10", "reset bus", rd_req_valid, 0);

    run_op(0, 0, 18'h01234, 16'h5A80, 16'h5A80, 3, -1, 0); // R4 program bit7, d7=1
    run_op(0, 0, 18'h00042, 16'h1234, 16'h1234, 5, -1, 0); // R4 program bit7, d7=0
    run_op(1, 0, 18'h3F000, 16'hABCD, 16'hFFFF, 4, -1, 0); // R4 R8 erase bit7
    run_op(0, 1, 18'h00777, 16'hC3C3, 16'hC3C3, 6, -1, 0); // R6 program toggle
    run_op(1, 1, 18'h10000, 16'h0000, 16'hFFFF, 7, -1, 0); // R6 erase toggle
    run_op(0, 0, 18'h00010, 16'h00F0, 16'h00F0, 0, -1, 0); // R4 immediate
    run_op(0, 1, 18'h00011, 16'h0F00, 16'h0F00, 0, -1, 0); // R6 first read alone
    run_op(0, 0, 18'h00020, 16'h8001, 16'h8001, 8, 2, 0);  // R5 lone early match
    run_op(1, 0, 18'h00021, 16'h0000, 16'hFFFF, 6, 3, 0);  // R5 erase lone match
    run_op(0, 0, 18'h00030, 16'h9999, 16'h9998, 2, -1, 0); // R7 mismatch bit7
    run_op(0, 1, 18'h00031, 16'h1111, 16'h1191, 3, -1, 0); // R7 mismatch toggle
    run_op(1, 0, 18'h00032, 16'h1234, 16'hFEFF, 2, -1, 0); // R8 erase odd word
    run_op(0, 0, 18'h00040, 16'h4444, 16'h4444, 1000, -1, 0); // R9 timeout bit7
    run_op(1, 1, 18'h00041, 16'h0000, 16'hFFFF, 1000, -1, 0); // R9 timeout toggle
    run_op(0, 0, 18'h00050, 16'h7E81, 16'h7E81, 20, -1, 1);   // R2 start while busy
    run_op(0, 1, 18'h00051, 16'h2468, 16'h2468, 20, -1, 1);   // R2 start while busy

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule